// File: doc/BRIEF.md
# Plug-and-play card control register file

This block holds the card-level configuration state of a plug-and-play expansion card. Software selects a register by writing its index to the address latch. It then writes a value through the write-data port, or reads the register back through a read-data port whose I/O address software chooses. The block tracks the card's phase (waiting for the initiation key, sleep, isolation, configuration), its card-select number and a saved copy of it, and the activate and I/O-range-check controls. It also holds the I/O base address, the IRQ level and a small resource-data store whose read pointer advances by itself.

Initiation-key detection and the serial isolation datapath are separate blocks. They report to this block through two single-cycle pulses: the key has been seen, and isolation has been won. The rest of the card takes its I/O decode enable and base address from this block. While the range-check mode is on, the block itself answers host reads across a 32-byte window at the base address.

Host read responses have no back-pressure: a response is a single-cycle valid pulse with data, and the requester must take it in that cycle. Only one read request is accepted per cycle. Write strobes carry no handshake either.

Top module: `pnp_card_ctl`

## Requirements
- R1: After reset the phase is wait-for-key (encoding 0; sleep 1, isolation 2, configuration 3), decode is off, the read-data port is invalid, the CSN is 0 and no response is given.
- R2: In wait-for-key, address-latch and data writes are ignored, and a key_ok pulse moves the card to sleep.
- R3: A data write to index 0x00 in any phase other than wait-for-key sets the read port to {value,2'b11}. The port is valid only in 0x200..0x3FF. A host read at a valid port, outside wait-for-key, returns the latched register's value with rsp_valid one cycle later.
- R4: A Wake write (index 0x03) whose value equals the CSN resets the resource pointer and pulses seed_pulse for one cycle. From sleep, the card goes to configuration if the value is nonzero and to isolation if it is zero. An iso_won pulse moves isolation to configuration.
- R5: A Wake value that differs from the CSN moves a card in configuration or isolation to sleep.
- R6: A write to index 0x06 in isolation or configuration loads the CSN and the saved CSN and enters configuration. Index 0x06 reads the CSN.
- R7: Index 0x04 reads resource byte k, equal to 0x3C + 5*k modulo 256, then advances k, which wraps after 16 bytes. Index 0x05 reads 0x01.
- R8: Index 0x30 bit 0 drives dec_en. Indices 0x60 and 0x61 hold the base high and low bytes, and 0x70 holds the IRQ level. Index 0x71 reads 0x02, and 0x74 and 0x75 read 0x04.
- R9: While index 0x31 bit 1 is set, a host read within base..base+31 returns 0x55 if bit 0 is set and 0xAA otherwise. Addresses outside the window get no response.
- R10: A write to index 0x02 acts bit by bit: bit 0 clears activate, range check, base and IRQ; bit 1 returns to wait-for-key; bit 2 clears the CSN and the saved CSN.
- R11: Setting bit 2 of a write to index 0xF6 clears the CSN but keeps the saved CSN, which reads at index 0xF5.
- R12: Unimplemented indices read 0x00 and ignore writes. Writes other than to 0x00, 0x02, 0x03 and 0x06 take effect only in configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Address-latch write strobe |
| idx_val | input | 8 | Register index written to the latch |
| dat_wr | input | 1 | Write-data strobe |
| dat_val | input | 8 | Data written to the latched register |
| key_ok | input | 1 | Pulse from the key detector |
| iso_won | input | 1 | Pulse from the isolation datapath |
| host_rd | input | 1 | Host I/O read request |
| host_addr | input | 16 | Host I/O read address |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data | output | 8 | Read response data |
| phase | output | 2 | Current phase |
| csn_o | output | 8 | Active card-select number |
| seed_pulse | output | 1 | Checksum reseed pulse on a Wake match |
| dec_en | output | 1 | I/O decode enable for the card |
| io_base | output | 16 | I/O base address |
| irq_lvl | output | 8 | IRQ level |
| rd_port | output | 16 | Current read-data port address |
| rd_port_ok | output | 1 | Read-data port lies in the legal range |

## Verification
Every write takes effect at the clock edge that samples its strobe, so phase, CSN, decode enable, base, IRQ, read port and seed_pulse are already updated one edge after the strobe. A read response appears exactly one cycle after host_rd, and the resource pointer has advanced by that same edge. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, when exactly one rising edge has passed. Each check therefore sees the first cycle in which the result is due.

// File: rtl/pnp_card_pkg.sv
package pnp_card_pkg;

  typedef enum logic [1:0] {
    PH_WAIT_KEY = 2'd0,
    PH_SLEEP    = 2'd1,
    PH_ISOL     = 2'd2,
    PH_CONFIG   = 2'd3
  } phase_t;

  localparam int DATA_W = 8;
  localparam int IO_W   = 16;

  localparam logic [7:0] IX_RDPORT   = 8'h00;
  localparam logic [7:0] IX_CFG_CTL  = 8'h02;
  localparam logic [7:0] IX_WAKE     = 8'h03;
  localparam logic [7:0] IX_RES      = 8'h04;
  localparam logic [7:0] IX_STATUS   = 8'h05;
  localparam logic [7:0] IX_CSN      = 8'h06;
  localparam logic [7:0] IX_ACT      = 8'h30;
  localparam logic [7:0] IX_RCHK     = 8'h31;
  localparam logic [7:0] IX_BASE_HI  = 8'h60;
  localparam logic [7:0] IX_BASE_LO  = 8'h61;
  localparam logic [7:0] IX_IRQ      = 8'h70;
  localparam logic [7:0] IX_IRQ_TYPE = 8'h71;
  localparam logic [7:0] IX_DMA0     = 8'h74;
  localparam logic [7:0] IX_DMA1     = 8'h75;
  localparam logic [7:0] IX_CSN_SAV  = 8'hF5;
  localparam logic [7:0] IX_VEND     = 8'hF6;

  localparam logic [15:0] RDPORT_LO = 16'h0200;
  localparam logic [15:0] RDPORT_HI = 16'h03FF;

  localparam logic [7:0] STATUS_VAL   = 8'h01;
  localparam logic [7:0] IRQ_TYPE_VAL = 8'h02;
  localparam logic [7:0] NO_DMA_VAL   = 8'h04;
  localparam logic [7:0] CHK_HI_VAL   = 8'h55;
  localparam logic [7:0] CHK_LO_VAL   = 8'hAA;

endpackage

// File: rtl/pnp_phase_ctl.sv
module pnp_phase_ctl
  import pnp_card_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] val,
  input  logic       key_ok,
  input  logic       iso_won,
  output phase_t     phase,
  output logic [7:0] csn,
  output logic [7:0] csn_sav,
  output logic       seed,
  output logic       ptr_clr
);

  logic wake_match;
  assign wake_match = wr_en && (idx == IX_WAKE) && (val == csn) && (phase != PH_WAIT_KEY);
  assign ptr_clr    = wake_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_WAIT_KEY;
      csn     <= '0;
      csn_sav <= '0;
      seed    <= 1'b0;
    end else begin
      seed <= 1'b0;
      if (phase == PH_WAIT_KEY) begin
        if (key_ok) phase <= PH_SLEEP;
      end else if (wr_en) begin
        case (idx)
          IX_CFG_CTL: begin
            if (val[2]) begin
              csn     <= '0;
              csn_sav <= '0;
            end
            if (val[1]) phase <= PH_WAIT_KEY;
          end
          IX_WAKE: begin
            if (val == csn) begin
              seed <= 1'b1;
              if (phase == PH_SLEEP)
                phase <= (val != 8'h00) ? PH_CONFIG : PH_ISOL;
            end else if (phase == PH_CONFIG || phase == PH_ISOL) begin
              phase <= PH_SLEEP;
            end
          end
          IX_CSN: begin
            if (phase == PH_ISOL || phase == PH_CONFIG) begin
              csn     <= val;
              csn_sav <= val;
              phase   <= PH_CONFIG;
            end
          end
          IX_VEND: begin
            if (phase == PH_CONFIG && val[2]) csn <= '0;
          end
          default: ;
        endcase
      end else if (iso_won && phase == PH_ISOL) begin
        phase <= PH_CONFIG;
      end
    end
  end

endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
  import pnp_card_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  val,
  input  phase_t      phase,
  output logic [7:0]  act,
  output logic [7:0]  rchk,
  output logic [15:0] base,
  output logic [7:0]  irq,
  output logic [15:0] port,
  output logic        port_ok
);

  logic [15:0] new_port;
  logic        new_ok;
  logic        live;
  logic        cfg;

  assign new_port = {6'b0, val, 2'b11};
  assign new_ok   = (new_port >= RDPORT_LO) && (new_port <= RDPORT_HI);
  assign live     = wr_en && (phase != PH_WAIT_KEY);
  assign cfg      = wr_en && (phase == PH_CONFIG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= '0;
      rchk    <= '0;
      base    <= '0;
      irq     <= '0;
      port    <= '0;
      port_ok <= 1'b0;
    end else begin
      if (live && idx == IX_RDPORT) begin
        port    <= new_port;
        port_ok <= new_ok;
      end
      if (live && idx == IX_CFG_CTL && val[0]) begin
        act  <= '0;
        rchk <= '0;
        base <= '0;
        irq  <= '0;
      end
      if (cfg) begin
        case (idx)
          IX_ACT:     act        <= val;
          IX_RCHK:    rchk       <= val;
          IX_BASE_HI: base[15:8] <= val;
          IX_BASE_LO: base[7:0]  <= val;
          IX_IRQ:     irq        <= val;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/pnp_res_store.sv
module pnp_res_store #(
  parameter int         DEPTH = 16,
  parameter logic [7:0] SEED  = 8'h3C,
  parameter int         STEP  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  output logic [7:0] byte_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [7:0]    bytes [DEPTH];
  logic [PW-1:0] ptr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    assign bytes[g] = SEED + 8'((g * STEP) % 256);
  end

  assign byte_o = bytes[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clr) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/pnp_card_ctl.sv
module pnp_card_ctl
  import pnp_card_pkg::*;
#(
  parameter int         RES_DEPTH = 16,
  parameter logic [7:0] RES_SEED  = 8'h3C,
  parameter int         RES_STEP  = 5,
  parameter int         WIN_SIZE  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idx_wr,
  input  logic [7:0]  idx_val,
  input  logic        dat_wr,
  input  logic [7:0]  dat_val,
  input  logic        key_ok,
  input  logic        iso_won,
  input  logic        host_rd,
  input  logic [15:0] host_addr,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic [1:0]  phase,
  output logic [7:0]  csn_o,
  output logic        seed_pulse,
  output logic        dec_en,
  output logic [15:0] io_base,
  output logic [7:0]  irq_lvl,
  output logic [15:0] rd_port,
  output logic        rd_port_ok
);

  localparam logic [15:0] WIN_LEN = 16'(WIN_SIZE);

  phase_t      ph;
  logic [7:0]  idx;
  logic [7:0]  csn_sav;
  logic [7:0]  act;
  logic [7:0]  rchk;
  logic [15:0] base;
  logic [7:0]  res_byte;
  logic        ptr_clr;
  logic        port_hit;
  logic        win_hit;
  logic [15:0] win_off;
  logic [7:0]  reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx <= '0;
    else if (idx_wr && ph != PH_WAIT_KEY)
      idx <= idx_val;
  end

  pnp_phase_ctl u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dat_wr),
    .idx     (idx),
    .val     (dat_val),
    .key_ok  (key_ok),
    .iso_won (iso_won),
    .phase   (ph),
    .csn     (csn_o),
    .csn_sav (csn_sav),
    .seed    (seed_pulse),
    .ptr_clr (ptr_clr)
  );

  pnp_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dat_wr),
    .idx     (idx),
    .val     (dat_val),
    .phase   (ph),
    .act     (act),
    .rchk    (rchk),
    .base    (base),
    .irq     (irq_lvl),
    .port    (rd_port),
    .port_ok (rd_port_ok)
  );

  assign port_hit = host_rd && rd_port_ok && (host_addr == rd_port) && (ph != PH_WAIT_KEY);
  assign win_off  = host_addr - base;
  assign win_hit  = host_rd && rchk[1] && (host_addr >= base) && (win_off < WIN_LEN);

  pnp_res_store #(
    .DEPTH (RES_DEPTH),
    .SEED  (RES_SEED),
    .STEP  (RES_STEP)
  ) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ptr_clr),
    .adv    (port_hit && idx == IX_RES),
    .byte_o (res_byte)
  );

  always_comb begin
    case (idx)
      IX_RES:      reg_q = res_byte;
      IX_STATUS:   reg_q = STATUS_VAL;
      IX_CSN:      reg_q = csn_o;
      IX_ACT:      reg_q = act;
      IX_RCHK:     reg_q = rchk;
      IX_BASE_HI:  reg_q = base[15:8];
      IX_BASE_LO:  reg_q = base[7:0];
      IX_IRQ:      reg_q = irq_lvl;
      IX_IRQ_TYPE: reg_q = IRQ_TYPE_VAL;
      IX_DMA0:     reg_q = NO_DMA_VAL;
      IX_DMA1:     reg_q = NO_DMA_VAL;
      IX_CSN_SAV:  reg_q = csn_sav;
      default:     reg_q = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= port_hit || win_hit;
      if (port_hit)
        rsp_data <= reg_q;
      else if (win_hit)
        rsp_data <= rchk[0] ? CHK_HI_VAL : CHK_LO_VAL;
    end
  end

  assign phase   = ph;
  assign dec_en  = act[0];
  assign io_base = base;

endmodule

// File: rtl/pnp_card_ctl_chk.sv
module pnp_card_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dat_wr,
  input logic        key_ok,
  input logic        iso_won,
  input logic        host_rd,
  input logic        rsp_valid,
  input logic [1:0]  phase,
  input logic        seed_pulse,
  input logic        dec_en,
  input logic [15:0] rd_port,
  input logic        rd_port_ok
);

  // R3
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(host_rd));

  // R3
  port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_port_ok |-> (rd_port[15:9] == 7'b0000001 && rd_port[1:0] == 2'b11));

  // R4
  seed_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_pulse |-> $past(dat_wr));

  // R2
  phase_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> $past(dat_wr || key_ok || iso_won));

  // R8
  decode_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_en) |-> $past(dat_wr));

endmodule

bind pnp_card_ctl pnp_card_ctl_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dat_wr     (dat_wr),
  .key_ok     (key_ok),
  .iso_won    (iso_won),
  .host_rd    (host_rd),
  .rsp_valid  (rsp_valid),
  .phase      (phase),
  .seed_pulse (seed_pulse),
  .dec_en     (dec_en),
  .rd_port    (rd_port),
  .rd_port_ok (rd_port_ok)
);

// File: tb/test_pnp_card_ctl.sv
module test_pnp_card_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr = 1'b0;
  logic [7:0]  idx_val = '0;
  logic        dat_wr = 1'b0;
  logic [7:0]  dat_val = '0;
  logic        key_ok = 1'b0;
  logic        iso_won = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [1:0]  phase;
  logic [7:0]  csn_o;
  logic        seed_pulse;
  logic        dec_en;
  logic [15:0] io_base;
  logic [7:0]  irq_lvl;
  logic [15:0] rd_port;
  logic        rd_port_ok;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pnp_card_ctl i_pnp_card_ctl (.*);

  localparam logic [3:0] OP_IX = 4'd0;
  localparam logic [3:0] OP_DW = 4'd1;
  localparam logic [3:0] OP_RD = 4'd2;
  localparam logic [15:0] PORT = 16'h0203;
  localparam int NV = 30;
  localparam logic [19:0] VEC [NV] = '{
    {OP_IX, 8'h00, 8'h00}, {OP_DW, 8'h80, 8'h00}, {OP_RD, 8'h05, 8'h01},
    {OP_IX, 8'h03, 8'h00}, {OP_DW, 8'h00, 8'h00}, {OP_IX, 8'h06, 8'h00},
    {OP_DW, 8'h05, 8'h00}, {OP_RD, 8'h06, 8'h05}, {OP_IX, 8'h60, 8'h00},
    {OP_DW, 8'h03, 8'h00}, {OP_IX, 8'h61, 8'h00}, {OP_DW, 8'h00, 8'h00},
    {OP_RD, 8'h60, 8'h03}, {OP_RD, 8'h61, 8'h00}, {OP_IX, 8'h70, 8'h00},
    {OP_DW, 8'h0A, 8'h00}, {OP_RD, 8'h70, 8'h0A}, {OP_RD, 8'h71, 8'h02},
    {OP_RD, 8'h74, 8'h04}, {OP_RD, 8'h75, 8'h04}, {OP_RD, 8'h04, 8'h3C},
    {OP_RD, 8'h04, 8'h41}, {OP_IX, 8'h30, 8'h00}, {OP_DW, 8'h01, 8'h00},
    {OP_RD, 8'h30, 8'h01}, {OP_RD, 8'h50, 8'h00}, {OP_IX, 8'h50, 8'h00},
    {OP_DW, 8'hFF, 8'h00}, {OP_RD, 8'h50, 8'h00}, {OP_RD, 8'hF5, 8'h05}
  };

  function automatic string req_of(input logic [7:0] ix);
    case (ix)
      8'h04, 8'h05: return "R7";
      8'h06:        return "R6";
      8'h30, 8'h60, 8'h61, 8'h70, 8'h71, 8'h74, 8'h75: return "R8";
      8'hF5:        return "R11";
      default:      return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ix(input logic [7:0] v);
    @(negedge clk); idx_wr = 1'b1; idx_val = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_val = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic pulse_key;
    @(negedge clk); key_ok = 1'b1;
    @(negedge clk); key_ok = 1'b0;
  endtask

  task automatic pulse_iso;
    @(negedge clk); iso_won = 1'b1;
    @(negedge clk); iso_won = 1'b0;
  endtask

  task automatic host_read(input logic [15:0] a, input string req,
                           input logic exp_v, input logic [7:0] exp_d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0;
    chk(req, {15'b0, rsp_valid}, {15'b0, exp_v});
    if (exp_v) chk(req, {8'b0, rsp_data}, {8'b0, exp_d});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {14'b0, phase}, 16'd0);
    chk("R1", {15'b0, dec_en}, 16'd0);
    chk("R1", {15'b0, rd_port_ok}, 16'd0);
    chk("R1", {15'b0, rsp_valid}, 16'd0);
    chk("R1", {8'b0, csn_o}, 16'd0);
    // R2 writes ignored before the key
    wr_ix(8'h00); wr_dat(8'h80);
    chk("R2", {15'b0, rd_port_ok}, 16'd0);
    pulse_key;
    chk("R2", {14'b0, phase}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][19:16])
        OP_IX: wr_ix(VEC[i][15:8]);
        OP_DW: wr_dat(VEC[i][15:8]);
        default: begin
          wr_ix(VEC[i][15:8]);
          host_read(PORT, req_of(VEC[i][15:8]), 1'b1, VEC[i][7:0]);
        end
      endcase
    end

    chk("R3", rd_port, PORT);
    chk("R6", {14'b0, phase}, 16'd3);
    chk("R6", {8'b0, csn_o}, 16'd5);
    chk("R8", {15'b0, dec_en}, 16'd1);
    chk("R8", io_base, 16'h0300);
    chk("R8", {8'b0, irq_lvl}, 16'h000A);

    // R9 range-check window
    wr_ix(8'h31); wr_dat(8'h03);
    host_read(16'h0305, "R9", 1'b1, 8'h55);
    host_read(16'h031F, "R9", 1'b1, 8'h55);
    host_read(16'h0320, "R9", 1'b0, 8'h00);
    host_read(16'h02FF, "R9", 1'b0, 8'h00);
    wr_dat(8'h02);
    host_read(16'h0300, "R9", 1'b1, 8'hAA);
    wr_dat(8'h00);
    host_read(16'h0300, "R9", 1'b0, 8'h00);

    // R5 wake mismatch
    wr_ix(8'h03); wr_dat(8'h07);
    chk("R5", {14'b0, phase}, 16'd1);
    // R12 write outside configuration ignored
    wr_ix(8'h70); wr_dat(8'h0B);
    // R4 wake match from sleep, nonzero
    wr_ix(8'h03); wr_dat(8'h05);
    chk("R4", {15'b0, seed_pulse}, 16'd1);
    chk("R4", {14'b0, phase}, 16'd3);
    chk("R12", {8'b0, irq_lvl}, 16'h000A);
    wr_ix(8'h04);
    host_read(PORT, "R4", 1'b1, 8'h3C);

    // R11 vendor control
    wr_ix(8'hF6); wr_dat(8'h04);
    chk("R11", {8'b0, csn_o}, 16'd0);
    wr_ix(8'hF5);
    host_read(PORT, "R11", 1'b1, 8'h05);

    // R10 config control bits
    wr_ix(8'h02); wr_dat(8'h04);
    wr_ix(8'hF5);
    host_read(PORT, "R10", 1'b1, 8'h00);
    wr_ix(8'h02); wr_dat(8'h01);
    chk("R10", {15'b0, dec_en}, 16'd0);
    chk("R10", io_base, 16'h0000);
    wr_dat(8'h02);
    chk("R10", {14'b0, phase}, 16'd0);
    host_read(PORT, "R3", 1'b0, 8'h00);

    // R3 port range boundaries
    pulse_key;
    chk("R2", {14'b0, phase}, 16'd1);
    wr_ix(8'h00); wr_dat(8'h7F);
    chk("R3", {15'b0, rd_port_ok}, 16'd0);
    wr_dat(8'hFF);
    chk("R3", {15'b0, rd_port_ok}, 16'd1);
    chk("R3", rd_port, 16'h03FF);

    // R4 wake zero into isolation, then isolation won
    wr_ix(8'h03); wr_dat(8'h00);
    chk("R4", {14'b0, phase}, 16'd2);
    pulse_iso;
    chk("R4", {14'b0, phase}, 16'd3);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule